// File: doc/BRIEF.md
# String Port-Input Transfer Engine

This block copies a run of elements from one I/O port into consecutive memory locations. A single command carries the port number, the starting destination pointer, the element width, the stepping direction, the address width, a repeat enable and a repeat count. For each element the engine issues a port read request, waits for the read data, and then issues a memory write of the same width at the current pointer. After the write, the pointer steps by the element width, up or down, and wraps inside the selected address width. With repeat enabled, the count drops by one per element.

The engine checks each command when it starts. A lock request, an illegal width or address mode, or a denied port access ends the command at once with a fault code, and no bus traffic takes place. A fault pulse from outside (standing in for paging or segment faults) aborts a running transfer. In that case the pointer and count keep the values they had after the last completed element, so the command can be reissued from where it stopped.

The three data interfaces use valid/ready. A valid, once raised, stays high with a stable payload until the matching ready is seen. The engine raises io_rsp_ready only while it waits for read data. At most one element is in flight: the read request, the read response and the memory write of one element are strictly ordered, and the next request follows only after the write handshake.

Top module: `strin_engine`

## Requirements
- R1: Every port read request of a command carries the 16-bit port number given at start, unchanged for all elements.
- R2: Element width code 0, 1 or 2 means 1, 2 or 4 bytes. The same code appears on io_req_size and mem_size. mem_data equals the read data with all bits above the element width cleared.
- R3: After each memory write, the pointer rises by the element width in bytes when the direction input is 0 and falls by it when the direction input is 1. The memory write address is the pointer before the step.
- R4: Address mode code 0, 1 or 2 selects a 16, 32 or 64-bit pointer. The step wraps modulo 2^N in the low N bits, and bits above N are left unchanged.
- R5: Address mode 0 with long mode set, address mode 2 with long mode clear, address mode 3, or width code 3 ends the command with fault code 2 and no accesses.
- R6: With repeat set, exactly count elements are moved and the count drops by one per element, ending at 0. With repeat clear, exactly one element is moved and the count is left unchanged.
- R7: With repeat set and a count of zero, done is pulsed in the cycle after start and no port or memory access occurs.
- R8: A set lock input ends the command with fault code 1 before any access. This check takes priority over every other check.
- R9: A denied port access at start ends the command with fault code 3 and no accesses.
- R10: A pulse on ext_fault during a transfer aborts it with fault code 4. After the abort no further accesses occur, and cur_ptr and cur_cnt hold their values after the last completed memory write.
- R11: io_req_valid and mem_valid are never high together. Each valid stays high, with a stable payload, until its ready is seen.
- R12: done and fault are single-cycle pulses, never high together, and busy is low whenever either one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted while idle |
| cmd_port | input | 16 | Port number |
| cmd_dst | input | 64 | Starting destination pointer |
| cmd_size | input | 2 | Element width code |
| cmd_dir | input | 1 | 0 = step up, 1 = step down |
| cmd_asz | input | 2 | Address mode code |
| cmd_long | input | 1 | Long (64-bit) mode |
| cmd_rep | input | 1 | Repeat enable |
| cmd_count | input | 32 | Repeat count |
| cmd_lock | input | 1 | Lock requested (illegal) |
| io_deny | input | 1 | Port access denied, sampled at start |
| ext_fault | input | 1 | External abort pulse |
| io_req_valid | output | 1 | Port read request valid |
| io_req_ready | input | 1 | Port read request accepted |
| io_req_port | output | 16 | Port number of request |
| io_req_size | output | 2 | Width code of request |
| io_rsp_valid | input | 1 | Read data valid |
| io_rsp_ready | output | 1 | Engine waits for read data |
| io_rsp_data | input | 32 | Read data |
| mem_valid | output | 1 | Memory write valid |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 64 | Write address |
| mem_data | output | 32 | Write data, zero-filled above width |
| mem_size | output | 2 | Write width code |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Fault pulse |
| fault_code | output | 3 | Last fault code, 0 when none |
| cur_ptr | output | 64 | Current destination pointer |
| cur_cnt | output | 32 | Current repeat count |

## Verification
On every cycle the assertions check the interface rules: one element in flight, valid held with a stable payload under back-pressure, the exclusive done and fault pulses, the count stepping once per repeated write, bits above a 16-bit pointer staying unchanged, and the lock fault that fires ahead of all else. Only the bench scenarios can show the data path end to end. These are the exact address sequence across wrap boundaries in both directions, the zero-filled write data, the element totals for repeated and single commands, and the restartable pointer and count left by a mid-transfer abort.

// File: rtl/strin_pkg.sv
package strin_pkg;
  // element width codes
  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;
  // address mode codes
  localparam logic [1:0] AM_16 = 2'd0;
  localparam logic [1:0] AM_32 = 2'd1;
  localparam logic [1:0] AM_64 = 2'd2;
  // fault codes
  localparam logic [2:0] FC_NONE  = 3'd0;
  localparam logic [2:0] FC_LOCK  = 3'd1;
  localparam logic [2:0] FC_MODE  = 3'd2;
  localparam logic [2:0] FC_DENY  = 3'd3;
  localparam logic [2:0] FC_ABORT = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_WR   = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/strin_admit.sv
module strin_admit
  import strin_pkg::*;
(
  input  logic       lock_i,
  input  logic [1:0] size_i,
  input  logic [1:0] asz_i,
  input  logic       long_i,
  input  logic       rep_i,
  input  logic       cnt_zero_i,
  input  logic       deny_i,
  output logic [2:0] code_o,
  output logic       empty_o
);
  logic mode_bad;

  always_comb begin
    mode_bad = (size_i == 2'd3) || (asz_i == 2'd3) ||
               (asz_i == AM_16 && long_i) || (asz_i == AM_64 && !long_i);
    if (lock_i)        code_o = FC_LOCK;
    else if (mode_bad) code_o = FC_MODE;
    else if (deny_i)   code_o = FC_DENY;
    else               code_o = FC_NONE;
    empty_o = (code_o == FC_NONE) && rep_i && cnt_zero_i;
  end
endmodule

// File: rtl/strin_ptr_step.sv
module strin_ptr_step
  import strin_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [1:0]        size_i,
  input  logic              dir_i,
  input  logic [1:0]        asz_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] MASK16 = ADDR_W'({16{1'b1}});
  localparam logic [ADDR_W-1:0] MASK32 = ADDR_W'({32{1'b1}});

  logic [ADDR_W-1:0] step, moved, wmask;

  always_comb begin
    step  = ADDR_W'(1) << size_i;
    moved = dir_i ? (ptr_i - step) : (ptr_i + step);
    case (asz_i)
      AM_16:   wmask = MASK16;
      AM_32:   wmask = MASK32;
      default: wmask = '1;
    endcase
    ptr_o = (ptr_i & ~wmask) | (moved & wmask);
  end
endmodule

// File: rtl/strin_engine.sv
module strin_engine
  import strin_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PORT_W-1:0] cmd_port,
  input  logic [ADDR_W-1:0] cmd_dst,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_dir,
  input  logic [1:0]        cmd_asz,
  input  logic              cmd_long,
  input  logic              cmd_rep,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_lock,
  input  logic              io_deny,
  input  logic              ext_fault,
  output logic              io_req_valid,
  input  logic              io_req_ready,
  output logic [PORT_W-1:0] io_req_port,
  output logic [1:0]        io_req_size,
  input  logic              io_rsp_valid,
  output logic              io_rsp_ready,
  input  logic [DATA_W-1:0] io_rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [1:0]        mem_size,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_code,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [CNT_W-1:0]  cur_cnt
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  xfer_state_e       st_q;
  logic [PORT_W-1:0] port_q;
  logic [1:0]        size_q, asz_q;
  logic              dir_q, rep_q;
  logic [ADDR_W-1:0] ptr_q, ptr_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q, width_mask;
  logic              done_q, fault_q;
  logic [2:0]        code_q, adm_code;
  logic              adm_empty, last_elem;

  strin_admit u_admit (
    .lock_i    (cmd_lock),
    .size_i    (cmd_size),
    .asz_i     (cmd_asz),
    .long_i    (cmd_long),
    .rep_i     (cmd_rep),
    .cnt_zero_i(cmd_count == '0),
    .deny_i    (io_deny),
    .code_o    (adm_code),
    .empty_o   (adm_empty)
  );

  strin_ptr_step #(.ADDR_W(ADDR_W)) u_step (
    .ptr_i (ptr_q),
    .size_i(size_q),
    .dir_i (dir_q),
    .asz_i (asz_q),
    .ptr_o (ptr_nx)
  );

  always_comb begin
    case (size_q)
      SZ_BYTE: width_mask = DATA_W'(8'hFF);
      SZ_WORD: width_mask = DATA_W'(16'hFFFF);
      default: width_mask = '1;
    endcase
    last_elem = !rep_q || (cnt_q == CNT_ONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      port_q  <= '0;
      size_q  <= SZ_BYTE;
      asz_q   <= AM_16;
      dir_q   <= 1'b0;
      rep_q   <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= FC_NONE;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          port_q <= cmd_port;
          size_q <= cmd_size;
          asz_q  <= cmd_asz;
          dir_q  <= cmd_dir;
          rep_q  <= cmd_rep;
          ptr_q  <= cmd_dst;
          cnt_q  <= cmd_count;
          code_q <= adm_code;
          if (adm_code != FC_NONE) fault_q <= 1'b1;
          else if (adm_empty)      done_q  <= 1'b1;
          else                     st_q    <= ST_REQ;
        end
        ST_REQ: begin
          if (ext_fault) begin
            fault_q <= 1'b1; code_q <= FC_ABORT; st_q <= ST_IDLE;
          end else if (io_req_ready) st_q <= ST_RSP;
        end
        ST_RSP: begin
          if (ext_fault) begin
            fault_q <= 1'b1; code_q <= FC_ABORT; st_q <= ST_IDLE;
          end else if (io_rsp_valid) begin
            data_q <= io_rsp_data & width_mask;
            st_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_ready) begin
            ptr_q <= ptr_nx;
            if (rep_q) cnt_q <= cnt_q - CNT_ONE;
          end
          if (ext_fault) begin
            fault_q <= 1'b1; code_q <= FC_ABORT; st_q <= ST_IDLE;
          end else if (mem_ready) begin
            if (last_elem) begin
              done_q <= 1'b1; st_q <= ST_IDLE;
            end else st_q <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign io_req_valid = (st_q == ST_REQ);
  assign io_req_port  = port_q;
  assign io_req_size  = size_q;
  assign io_rsp_ready = (st_q == ST_RSP);
  assign mem_valid    = (st_q == ST_WR);
  assign mem_addr     = ptr_q;
  assign mem_data     = data_q;
  assign mem_size     = size_q;
  assign busy         = (st_q != ST_IDLE);
  assign done         = done_q;
  assign fault        = fault_q;
  assign fault_code   = code_q;
  assign cur_ptr      = ptr_q;
  assign cur_cnt      = cnt_q;

  // R11
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req_valid && mem_valid));
  // R11
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req_valid && !io_req_ready && !ext_fault) |=>
      (io_req_valid && $stable(io_req_port) && $stable(io_req_size)));
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !ext_fault) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!(done && fault) && !busy));
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && rep_q) |=> (cur_cnt == $past(cur_cnt) - CNT_ONE));
  // R4
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && asz_q == AM_16) |=>
      (cur_ptr[ADDR_W-1:16] == $past(cur_ptr[ADDR_W-1:16])));
  // R8
  lock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cmd_lock) |=> (fault && fault_code == FC_LOCK && !io_req_valid));
endmodule

// File: tb/strin_engine_test.sv
module strin_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 0;
  logic [15:0] cmd_port = 0;
  logic [63:0] cmd_dst = 0;
  logic [1:0]  cmd_size = 0, cmd_asz = 0;
  logic        cmd_dir = 0, cmd_long = 0, cmd_rep = 0, cmd_lock = 0, io_deny = 0, ext_fault = 0;
  logic [31:0] cmd_count = 0;
  logic        io_req_valid, io_req_ready = 0, io_rsp_valid = 0, io_rsp_ready;
  logic [15:0] io_req_port;
  logic [1:0]  io_req_size, mem_size;
  logic [31:0] io_rsp_data = 0, mem_data, cur_cnt;
  logic        mem_valid, mem_ready = 0, busy, done, fault;
  logic [63:0] mem_addr, cur_ptr;
  logic [2:0]  fault_code;

  strin_engine uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit sim_on = 0;

  // model state
  logic [15:0] m_port;
  logic [1:0]  m_size, m_asz;
  logic        m_dir, m_rep;
  logic [63:0] m_ptr;
  logic [31:0] m_cnt;
  int m_idx = 0, rd_idx = 0, abort_at = -1;
  bit pend = 0, rsp_hs = 0, fired = 0;
  int dly = 0;
  logic [31:0] pend_data;
  int hold_bias = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pdata(input logic [15:0] p, input int i);
    return {p, 16'(i * 37 + 5)} ^ 32'hA5C3_0F1E;
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] sz);
    if (sz == 2'd0) return 32'h0000_00FF;
    if (sz == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] p, input logic [1:0] sz,
                                      input logic d, input logic [1:0] a);
    logic [15:0] l16;
    logic [31:0] l32;
    logic [63:0] l64;
    int unsigned inc;
    inc = 1 << sz;
    case (a)
      2'd0: begin l16 = d ? p[15:0] - 16'(inc) : p[15:0] + 16'(inc); return {p[63:16], l16}; end
      2'd1: begin l32 = d ? p[31:0] - inc : p[31:0] + inc; return {p[63:32], l32}; end
      default: begin l64 = d ? p - 64'(inc) : p + 64'(inc); return l64; end
    endcase
  endfunction

  // slave models and monitor, all at the falling edge
  always @(negedge clk) if (sim_on) begin
    if (rsp_hs) begin io_rsp_valid = 0; rsp_hs = 0; end
    if (io_rsp_valid) begin
      if (io_rsp_ready) rsp_hs = 1;
    end else if (pend) begin
      if (dly == 0) begin
        io_rsp_valid = 1; io_rsp_data = pend_data; pend = 0;
        if (io_rsp_ready) rsp_hs = 1;
      end else dly--;
    end
    io_req_ready = ($urandom % 4) >= hold_bias;
    if (io_req_valid && io_req_ready) begin
      chk(io_req_port == m_port, "R1", "request port", 64'(io_req_port), 64'(m_port));
      chk(io_req_size == m_size, "R2", "request width", 64'(io_req_size), 64'(m_size));
      pend = 1; dly = $urandom % 3;
      pend_data = pdata(io_req_port, rd_idx); rd_idx++;
    end
    mem_ready = ($urandom % 4) >= hold_bias;
    if (mem_valid && mem_ready) begin
      chk(mem_addr == m_ptr, "R3", "write address", mem_addr, m_ptr);
      chk(mem_size == m_size, "R2", "write width", 64'(mem_size), 64'(m_size));
      chk(mem_data == (pdata(m_port, m_idx) & wmask(m_size)), "R2", "write data",
          64'(mem_data), 64'(pdata(m_port, m_idx) & wmask(m_size)));
      m_ptr = nxt(m_ptr, m_size, m_dir, m_asz);
      if (m_rep) m_cnt = m_cnt - 1;
      m_idx++;
    end
    if (ext_fault) ext_fault = 0;
    else if (!fired && abort_at >= 0 && busy && m_idx == abort_at) begin
      ext_fault = 1; fired = 1;
    end
  end

  task automatic run_op(input logic [15:0] port, input logic [63:0] dst,
                        input logic [1:0] sz, input logic d, input logic [1:0] a,
                        input logic lng, input logic rep, input logic [31:0] cnt,
                        input logic lk, input logic dn, input int ab,
                        input logic [2:0] exp_code, input int exp_elems, input string req);
    bit seen_done, seen_fault;
    int wait_n;
    m_port = port; m_size = sz; m_dir = d; m_asz = a; m_rep = rep;
    m_ptr = dst; m_cnt = cnt; m_idx = 0; rd_idx = 0;
    pend = 0; rsp_hs = 0; io_rsp_valid = 0; abort_at = ab; fired = 0;
    @(negedge clk);
    cmd_port = port; cmd_dst = dst; cmd_size = sz; cmd_dir = d; cmd_asz = a;
    cmd_long = lng; cmd_rep = rep; cmd_count = cnt; cmd_lock = lk; io_deny = dn;
    start = 1;
    @(negedge clk);
    start = 0; cmd_lock = 0; io_deny = 0;
    seen_done = 0; seen_fault = 0; wait_n = 0;
    while (!(done || fault) && wait_n < 3000) begin
      @(negedge clk); wait_n++;
    end
    seen_done = done; seen_fault = fault;
    chk(seen_done || seen_fault, req, "operation ended", 64'(wait_n), 64'd0);
    if (exp_code == 3'd0)
      chk(seen_done && !seen_fault && !busy, "R12", "done pulse alone", 64'({seen_done, seen_fault, busy}), 64'b100);
    else
      chk(seen_fault && fault_code == exp_code && !busy, req, "fault code", 64'(fault_code), 64'(exp_code));
    @(negedge clk);
    chk(!done && !fault, "R12", "single-cycle pulse", 64'({done, fault}), 64'd0);
    repeat (4) @(negedge clk);
    chk(m_idx == exp_elems, req, "element total", 64'(m_idx), 64'(exp_elems));
    chk(cur_ptr == m_ptr, req, "final pointer", cur_ptr, m_ptr);
    chk(cur_cnt == m_cnt, req, "final count", 64'(cur_cnt), 64'(m_cnt));
    chk(!io_req_valid && !mem_valid, req, "bus quiet", 64'({io_req_valid, mem_valid}), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    sim_on = 1;
    @(negedge clk);
    chk(!busy && !done && !fault && !io_req_valid && !mem_valid && fault_code == 0,
        "R12", "reset state", 64'({busy, done, fault, io_req_valid, mem_valid}), 64'd0);

    // R8: lock wins even with bad mode and denial
    run_op(16'h0080, 64'h1000, 2'd0, 0, 2'd0, 1, 1, 32'd3, 1, 1, -1, 3'd1, 0, "R8");
    // R5: 16-bit in long mode, 64-bit outside it, width code 3
    run_op(16'h0081, 64'h2000, 2'd1, 0, 2'd0, 1, 1, 32'd3, 0, 0, -1, 3'd2, 0, "R5");
    run_op(16'h0082, 64'h2000, 2'd1, 0, 2'd2, 0, 0, 32'd3, 0, 0, -1, 3'd2, 0, "R5");
    run_op(16'h0083, 64'h2000, 2'd3, 0, 2'd1, 0, 0, 32'd3, 0, 0, -1, 3'd2, 0, "R5");
    // R9: denied port
    run_op(16'hFFFF, 64'h3000, 2'd2, 0, 2'd1, 0, 1, 32'd2, 0, 1, -1, 3'd3, 0, "R9");
    // R7: repeat with zero count
    run_op(16'h0060, 64'h4000, 2'd2, 0, 2'd1, 0, 1, 32'd0, 0, 0, -1, 3'd0, 0, "R7");
    // R4: 16-bit wrap downward, byte
    run_op(16'h0001, 64'hAAAA_BBBB_CCCC_0000, 2'd0, 1, 2'd0, 0, 1, 32'd3, 0, 0, -1, 3'd0, 3, "R4");
    chk(cur_ptr == 64'hAAAA_BBBB_CCCC_FFFD, "R4", "16-bit wrap result", cur_ptr, 64'hAAAA_BBBB_CCCC_FFFD);
    // R4: 32-bit wrap upward, dword
    run_op(16'h0002, 64'h1234_5678_FFFF_FFFC, 2'd2, 0, 2'd1, 1, 1, 32'd2, 0, 0, -1, 3'd0, 2, "R4");
    chk(cur_ptr == 64'h1234_5678_0000_0004, "R4", "32-bit wrap result", cur_ptr, 64'h1234_5678_0000_0004);
    // R6: single element, count untouched
    run_op(16'h0003, 64'h5000, 2'd1, 0, 2'd2, 1, 0, 32'd9, 0, 0, -1, 3'd0, 1, "R6");
    chk(cur_cnt == 32'd9, "R6", "count kept without repeat", 64'(cur_cnt), 64'd9);
    // R10: abort after two elements
    run_op(16'h0004, 64'h6000, 2'd1, 0, 2'd1, 0, 1, 32'd6, 0, 0, 2, 3'd4, 2, "R10");
    chk(cur_cnt == 32'd4 && cur_ptr == 64'h6004, "R10", "restart point", cur_ptr, 64'h6004);
    run_op(16'h0005, 64'h7000, 2'd0, 1, 2'd1, 0, 1, 32'd5, 0, 0, 0, 3'd4, 0, "R10");

    // random commands, with tight and loose back-pressure
    for (int n = 0; n < 60; n++) begin
      logic lng, rep;
      logic [1:0] sz, a;
      logic [31:0] cnt;
      logic [63:0] dst;
      hold_bias = (n < 30) ? 1 : 3;
      lng = $urandom % 2;
      a = lng ? 2'(1 + $urandom % 2) : 2'($urandom % 2);
      sz = 2'($urandom % 3);
      rep = ($urandom % 4) != 0;
      cnt = $urandom % 6;
      dst = {$urandom, $urandom};
      if (n % 3 == 0) dst[15:0] = 16'hFFFE;
      if (n % 3 == 1) dst[31:0] = 32'h0000_0001;
      run_op(16'($urandom), dst, sz, 1'($urandom % 2), a, lng, rep, cnt, 0, 0, -1, 3'd0,
             rep ? int'(cnt) : 1, "R6");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule